// File: doc/BRIEF.md
# Slow-Rate Infrared Receive Frame Unwrapper

This block sits in the receive byte path of a slow-rate infrared link, right after a UART-style byte receiver. It watches the incoming byte stream for the frame opening flag (0xC0). It removes the opening flag, the closing flag (0xC1), any leading padding and the escape bytes. Only the unescaped payload, with its 16-bit check field still attached, is sent to the output. Each frame ends with a one-cycle close pulse. The pulse carries three error flags: length overrun, missing close flag, and escape abort.

A 12-bit counter tracks how many bytes of the current frame have been passed on. A programmable 12-bit limit caps the frame size. The two flag values can be read as a fixed 16-bit word. The filter runs when the link is in slow-rate mode, or when a test input forces it on in any mode. CRC checking is left to a later stage.

Top module: `sir_unwrap`

## Requirements
- R1: `flag_word` always reads 0xC0 at bits [7:0] and 0xC1 at bits [15:8], including during and after reset.
- R2: Outside a frame, every byte except 0xC0 is discarded with no output. This includes 0xFF padding ahead of the opening flag. A 0xC0 opens a frame.
- R3: Payload bytes inside a frame appear on `out_byte` with `out_valid` one cycle after they are accepted, in arrival order. A 0xC1 produces a close pulse (`out_last`) with all three error flags low, and no data byte.
- R4: Inside a frame, the escape byte 0x7D is dropped, and the byte that follows it is output XORed with 0x20.
- R5: A 0xC0 inside an open frame closes that frame with a close pulse that has `err_noend` set. It then opens a new frame.
- R6: `byte_count` equals the number of bytes output in the current frame. It returns to 0 when a 0xC0 opens a frame.
- R7: A payload byte that would push the count above `max_len` is not output. Every following byte up to the next flag is also discarded. The close pulse then carries `err_len`, and `byte_count` stays at `max_len`. A frame of exactly `max_len` bytes closes without error.
- R8: An escape byte followed directly by a flag closes the frame with `err_abort` set. A 0xC0 then opens a new frame, and a 0xC1 returns to hunting for a frame.
- R9: The filter works only while `sir_mode` or `filt_test` is high. When both are low, no output is produced, and any open frame is dropped without a close pulse.
- R10: `out_valid` and `out_last` are never high together, and an error flag is high only together with `out_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sir_mode | input | 1 | Link runs at slow rate; enables the filter |
| filt_test | input | 1 | Forces the filter on in any mode |
| max_len | input | 12 | Largest number of output bytes accepted per frame |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Received byte |
| out_valid | output | 1 | Output payload byte strobe |
| out_byte | output | 8 | Unescaped payload byte |
| out_last | output | 1 | Frame close pulse |
| err_len | output | 1 | Frame exceeded `max_len` (with `out_last`) |
| err_noend | output | 1 | Frame cut by a new opening flag (with `out_last`) |
| err_abort | output | 1 | Escape byte followed by a flag (with `out_last`) |
| byte_count | output | 12 | Bytes output in the current frame |
| flag_word | output | 16 | Constant flag values {0xC1, 0xC0} |

## Verification
The bound checker checks these rules on every cycle:
- data strobes and close pulses never overlap;
- error flags only appear with a close pulse;
- each data byte advances `byte_count` by exactly one, without passing the limit in force;
- nothing comes out in a cycle that follows a disabled input cycle.

Only the directed scenarios can show the byte-level behaviour:
- that padding is discarded;
- that escaped bytes come out with the right values;
- which error flag goes with each malformed frame;
- that a frame of exactly `max_len` bytes passes cleanly while one byte more is cut.

// File: rtl/sir_unwrap_pkg.sv
package sir_unwrap_pkg;
  localparam logic [7:0] FLAG_OPEN  = 8'hC0;
  localparam logic [7:0] FLAG_CLOSE = 8'hC1;
  localparam logic [7:0] ESC_MARK   = 8'h7D;
  localparam logic [7:0] ESC_FLIP   = 8'h20;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_BODY  = 2'd1,
    ST_ESC   = 2'd2,
    ST_DRAIN = 2'd3
  } rx_state_t;
endpackage

// File: rtl/sir_byte_class.sv
module sir_byte_class
  import sir_unwrap_pkg::*;
(
  input  logic [7:0] byte_in,
  output logic       is_open,
  output logic       is_close,
  output logic       is_esc
);
  always_comb begin
    is_open  = (byte_in == FLAG_OPEN);
    is_close = (byte_in == FLAG_CLOSE);
    is_esc   = (byte_in == ESC_MARK);
  end
endmodule

// File: rtl/sir_len_guard.sv
module sir_len_guard #(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [LW-1:0] limit,
  output logic [LW-1:0] count,
  output logic          at_limit
);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign count    = cnt_q;
  assign at_limit = (cnt_q >= limit);
endmodule

// File: rtl/sir_unwrap.sv
module sir_unwrap
  import sir_unwrap_pkg::*;
#(
  parameter int LW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sir_mode,
  input  logic          filt_test,
  input  logic [LW-1:0] max_len,
  input  logic          in_valid,
  input  logic [DW-1:0] in_byte,
  output logic          out_valid,
  output logic [DW-1:0] out_byte,
  output logic          out_last,
  output logic          err_len,
  output logic          err_noend,
  output logic          err_abort,
  output logic [LW-1:0] byte_count,
  output logic [2*DW-1:0] flag_word
);
  localparam int FW = 2 * DW;

  rx_state_t st_q, st_d;
  logic active;
  logic b_open, b_close, b_esc;
  logic cnt_clr, cnt_inc, at_limit;
  logic emit_data, emit_last, e_len, e_noend, e_abort;
  logic [DW-1:0] emit_byte;

  assign active    = sir_mode | filt_test;
  assign flag_word = FW'({FLAG_CLOSE, FLAG_OPEN});

  sir_byte_class u_class (
    .byte_in (in_byte),
    .is_open (b_open),
    .is_close(b_close),
    .is_esc  (b_esc)
  );

  sir_len_guard #(.LW(LW)) u_len (
    .clk     (clk),
    .rst     (rst),
    .clr     (cnt_clr),
    .inc     (cnt_inc),
    .limit   (max_len),
    .count   (byte_count),
    .at_limit(at_limit)
  );

  always_comb begin
    st_d      = st_q;
    cnt_clr   = 1'b0;
    emit_data = 1'b0;
    emit_byte = in_byte;
    emit_last = 1'b0;
    e_len     = 1'b0;
    e_noend   = 1'b0;
    e_abort   = 1'b0;
    if (!active) begin
      st_d = ST_HUNT;
    end else if (in_valid) begin
      case (st_q)
        ST_HUNT: begin
          if (b_open) begin
            st_d    = ST_BODY;
            cnt_clr = 1'b1;
          end
        end
        ST_BODY: begin
          if (b_open) begin
            emit_last = 1'b1;
            e_noend   = 1'b1;
            cnt_clr   = 1'b1;
          end else if (b_close) begin
            emit_last = 1'b1;
            st_d      = ST_HUNT;
          end else if (b_esc) begin
            st_d = ST_ESC;
          end else if (at_limit) begin
            st_d = ST_DRAIN;
          end else begin
            emit_data = 1'b1;
          end
        end
        ST_ESC: begin
          if (b_open || b_close) begin
            emit_last = 1'b1;
            e_abort   = 1'b1;
            cnt_clr   = b_open;
            st_d      = b_open ? ST_BODY : ST_HUNT;
          end else if (at_limit) begin
            st_d = ST_DRAIN;
          end else begin
            emit_data = 1'b1;
            emit_byte = in_byte ^ ESC_FLIP;
            st_d      = ST_BODY;
          end
        end
        default: begin
          if (b_open || b_close) begin
            emit_last = 1'b1;
            e_len     = 1'b1;
            e_noend   = b_open;
            cnt_clr   = b_open;
            st_d      = b_open ? ST_BODY : ST_HUNT;
          end
        end
      endcase
    end
  end

  assign cnt_inc = emit_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_HUNT;
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_last  <= 1'b0;
      err_len   <= 1'b0;
      err_noend <= 1'b0;
      err_abort <= 1'b0;
    end else begin
      st_q      <= st_d;
      out_valid <= emit_data;
      if (emit_data) out_byte <= emit_byte;
      out_last  <= emit_last;
      err_len   <= e_len;
      err_noend <= e_noend;
      err_abort <= e_abort;
    end
  end
endmodule

// File: rtl/sir_unwrap_chk.sv
module sir_unwrap_chk #(
  parameter int LW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          sir_mode,
  input logic          filt_test,
  input logic          in_valid,
  input logic [LW-1:0] max_len,
  input logic          out_valid,
  input logic          out_last,
  input logic          err_len,
  input logic          err_noend,
  input logic          err_abort,
  input logic [LW-1:0] byte_count
);
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_last));

  assert_err_with_last_R10: assert property (@(posedge clk) disable iff (rst)
    (err_len || err_noend || err_abort) |-> out_last);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (byte_count == $past(byte_count) + 1'b1));

  assert_count_in_limit_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (byte_count <= $past(max_len)));

  assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(sir_mode || filt_test) |-> (!out_valid && !out_last));

  assert_no_out_without_in_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> (!out_valid && !out_last));
endmodule

bind sir_unwrap sir_unwrap_chk #(.LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sir_mode  (sir_mode),
  .filt_test (filt_test),
  .in_valid  (in_valid),
  .max_len   (max_len),
  .out_valid (out_valid),
  .out_last  (out_last),
  .err_len   (err_len),
  .err_noend (err_noend),
  .err_abort (err_abort),
  .byte_count(byte_count)
);

// File: tb/sim_sir_unwrap.sv
module sim_sir_unwrap;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sir_mode = 1'b1;
  logic        filt_test = 1'b0;
  logic [11:0] max_len = 12'd100;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        out_valid, out_last, err_len, err_noend, err_abort;
  logic [7:0]  out_byte;
  logic [11:0] byte_count;
  logic [15:0] flag_word;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] got [64];
  int got_n = 0;
  logic [2:0] lerr [8];
  int last_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sir_unwrap u0 (
    .clk(clk), .rst(rst), .sir_mode(sir_mode), .filt_test(filt_test),
    .max_len(max_len), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last),
    .err_len(err_len), .err_noend(err_noend), .err_abort(err_abort),
    .byte_count(byte_count), .flag_word(flag_word)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && got_n < 64) begin got[got_n] = out_byte; got_n++; end
      if (out_last && last_n < 8) begin lerr[last_n] = {err_len, err_noend, err_abort}; last_n++; end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_byte = b;
  endtask

  task automatic settle();
    @(negedge clk); in_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_cap();
    got_n = 0; last_n = 0;
  endtask

  task automatic expect_bytes(input string tag, input logic [7:0] e [], input int n);
    check(got_n == n, {tag, " count"}, got_n, n);
    for (int i = 0; i < n && i < got_n; i++)
      check(got[i] == e[i], tag, got[i], e[i]);
  endtask

  task automatic t_reset();
    check(!out_valid && !out_last, "R3 reset outputs", {out_valid, out_last}, 0);
    check(byte_count == 12'd0, "R6 reset count", byte_count, 0);
    check(flag_word == 16'hC1C0, "R1 flag word", flag_word, 16'hC1C0);
  endtask

  task automatic t_basic();
    clear_cap();
    send(8'h33); send(8'hFF); send(8'hFF); send(8'hC0);
    send(8'h11); send(8'h22); send(8'h33); send(8'h44); send(8'hC1);
    send(8'h55); send(8'hFF);
    settle();
    expect_bytes("R2 R3 basic payload", '{8'h11, 8'h22, 8'h33, 8'h44}, 4);
    check(last_n == 1, "R3 one close pulse", last_n, 1);
    check(lerr[0] == 3'b000, "R3 clean close", lerr[0], 0);
    check(byte_count == 12'd4, "R6 count after frame", byte_count, 4);
    check(flag_word == 16'hC1C0, "R1 flag word later", flag_word, 16'hC1C0);
  endtask

  task automatic t_escape();
    clear_cap();
    send(8'hC0); send(8'h7D); send(8'hE0); send(8'h7D); send(8'h5D);
    send(8'h7D); send(8'hE1); send(8'h55); send(8'hC1);
    settle();
    expect_bytes("R4 escape", '{8'hC0, 8'h7D, 8'hC1, 8'h55}, 4);
    check(last_n == 1 && lerr[0] == 3'b000, "R4 escape close", lerr[0], 0);
  endtask

  task automatic t_noend();
    clear_cap();
    send(8'hC0); send(8'hAA); send(8'hBB); send(8'hC0);
    send(8'hCC); send(8'hC1);
    settle();
    expect_bytes("R5 noend", '{8'hAA, 8'hBB, 8'hCC}, 3);
    check(last_n == 2, "R5 two closes", last_n, 2);
    check(lerr[0] == 3'b010, "R5 missing end flag", lerr[0], 3'b010);
    check(lerr[1] == 3'b000, "R5 second frame clean", lerr[1], 0);
    check(byte_count == 12'd1, "R6 count reset on reopen", byte_count, 1);
  endtask

  task automatic t_length();
    clear_cap();
    max_len = 12'd3;
    send(8'hC0); send(8'h01); send(8'h02); send(8'h03);
    send(8'h04); send(8'h05); send(8'h7D); send(8'h06); send(8'hC1);
    settle();
    expect_bytes("R7 length cut", '{8'h01, 8'h02, 8'h03}, 3);
    check(last_n == 1 && lerr[0] == 3'b100, "R7 length error", lerr[0], 3'b100);
    check(byte_count == 12'd3, "R7 count held", byte_count, 3);
    clear_cap();
    send(8'hC0); send(8'h0A); send(8'h0B); send(8'h0C); send(8'hC1);
    settle();
    expect_bytes("R7 exact length", '{8'h0A, 8'h0B, 8'h0C}, 3);
    check(last_n == 1 && lerr[0] == 3'b000, "R7 exact no error", lerr[0], 0);
    max_len = 12'd100;
  endtask

  task automatic t_abort();
    clear_cap();
    send(8'hC0); send(8'h12); send(8'h7D); send(8'hC1);
    send(8'h34); send(8'hC0); send(8'h7D); send(8'hC0); send(8'h56); send(8'hC1);
    settle();
    expect_bytes("R8 abort", '{8'h12, 8'h56}, 2);
    check(last_n == 3, "R8 three closes", last_n, 3);
    check(lerr[0] == 3'b001, "R8 abort on close flag", lerr[0], 1);
    check(lerr[1] == 3'b001, "R8 abort on open flag", lerr[1], 1);
    check(lerr[2] == 3'b000, "R8 frame after abort", lerr[2], 0);
  endtask

  task automatic t_enable();
    clear_cap();
    sir_mode = 1'b0; filt_test = 1'b0;
    send(8'hC0); send(8'h77); send(8'hC1);
    settle();
    check(got_n == 0 && last_n == 0, "R9 off produces nothing", got_n + last_n, 0);
    sir_mode = 1'b1;
    send(8'hC0); send(8'h21);
    @(negedge clk); in_valid = 1'b0; sir_mode = 1'b0;
    @(negedge clk); sir_mode = 1'b1;
    send(8'h22); send(8'hC1);
    settle();
    check(got_n == 1 && last_n == 0, "R9 drop on disable", got_n * 16 + last_n, 16);
    clear_cap();
    sir_mode = 1'b0; filt_test = 1'b1;
    send(8'hC0); send(8'h99); send(8'hC1);
    settle();
    expect_bytes("R9 test override", '{8'h99}, 1);
    check(last_n == 1, "R9 test override close", last_n, 1);
    sir_mode = 1'b1; filt_test = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_basic();
    t_escape();
    t_noend();
    t_length();
    t_abort();
    t_enable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule